// File: doc/BRIEF.md
# Tick-Paced Two-Wire Register Master

This block is the only master on a two-wire serial bus. It configures slave devices through a clock line and an open-drain data line. Nothing moves on the bus unless an external tick enable pulses. Each tick advances the bus by one step, so the tick rate alone sets the serial clock rate. For example, a tick near 210 kHz gives a bus clock of about 70 kHz.

To run a transfer, the host first fills a small byte buffer through a load port. It then pulses a start request carrying a command and a byte count. The count covers every byte on the wire, including the device address and the register address.

- A write streams the buffer out in order.
- A read sends the two address bytes, then inserts a repeated start by itself. It re-sends the device address with the read bit set and collects the returned bytes into an output buffer.

A slave that fails to acknowledge aborts the transfer with a stop and raises an error flag. A busy flag covers the whole transfer. A one-cycle done pulse marks the end of the final stop.

Top module: `twi_reg_master`

## Requirements
- R1: After reset, and whenever no transfer is running, the clock output is high, the data line is released (`sda_low_o` = 0), and `busy_o`, `done_o` and `err_o` are low.
- R2: A line change occurs only in the cycle after a tick. Each such change alters at most one of the two lines. Ticks while idle change nothing.
- R3: A start request is accepted only when idle and only in these cases:
  - command 2 (write) with a count from 1 to TX_BYTES;
  - command 1 (read) with a count from 4 to RX_BYTES+3.

  Any other request is ignored and no transfer begins.
- R4: The line steps are as follows. A start condition lowers data while the clock is high, then lowers the clock. Each bit sets data while the clock is low, then raises the clock, then lowers it. A stop lowers data, raises the clock, then releases data.
- R5: A write sends buffer byte 0 with bit 0 forced to 0, then buffer bytes 1 to count-1. Every byte goes most significant bit first.
- R6: After each sent byte, the master releases data for a ninth clock and samples it on the tick that lowers the clock. If the line is high, no further byte is sent and a stop follows.
- R7: A read sends buffer byte 0 with bit 0 forced to 0, then buffer byte 1. It then issues a repeated start: release data, raise the clock, lower data, lower the clock. Next it sends buffer byte 0 with bit 0 forced to 1. It then receives count-3 bytes.
- R8: Received bits are sampled on the clock-lowering tick, most significant bit first. Received byte k is stored at `rx_data_o[8k+7:8k]`.
- R9: The master acknowledges each received byte by holding data low through the ninth clock. After the final byte it leaves data released, then issues a stop.
- R10: Busy timing and re-triggering work as follows:
  - `busy_o` rises in the cycle after an accepted start.
  - `busy_o` falls in the cycle after the final stop tick, together with a one-cycle `done_o` pulse.
  - A start request while busy is ignored, including one coinciding with the final stop tick.
- R11: `err_o` rises only during a transfer whose slave failed to acknowledge. It stays high until the next accepted start clears it.
- R12: Buffer loads requested while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Bus step enable, one step per pulse |
| start_i | input | 1 | Start request |
| cmd_i | input | 2 | Command: 1 read, 2 write |
| count_i | input | CW | Total bytes on the wire, addresses included |
| load_i | input | 1 | Write one transmit buffer byte |
| load_idx_i | input | TXW | Transmit buffer index |
| load_byte_i | input | 8 | Transmit buffer data |
| sda_i | input | 1 | Sampled level of the data line |
| scl_o | output | 1 | Bus clock, push-pull |
| sda_low_o | output | 1 | Data line pull-down enable (1 drives low) |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at end of stop |
| err_o | output | 1 | Missing acknowledge seen |
| rx_data_o | output | RX_BYTES*8 | Received bytes, byte k at bits 8k+7:8k |

## Verification
The collision of interest is a start request arriving on the very edge that executes the last step of the stop. The controller is still busy in that cycle, so the request must be dropped. The bench provokes this by raising the start request together with the final tick of a write. The cycle-by-cycle model then expects busy to fall with the done pulse and stay low, with the bus idle afterwards. A second overlap is tested by issuing a buffer load on the first tick of a running write, aimed at a byte not yet fetched. The reference sequence, built from the old buffer contents, must still match on every clock.

// File: rtl/twi_pkg.sv
package twi_pkg;

    localparam logic [1:0] CMD_READ  = 2'd1;
    localparam logic [1:0] CMD_WRITE = 2'd2;

    // Bus symbols executed by the line engine
    typedef enum logic [1:0] {
        SYM_START,
        SYM_RSTART,
        SYM_BIT,
        SYM_STOP
    } twi_sym_e;

    // Transfer controller states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_TXBIT,
        ST_TXACK,
        ST_RSTART,
        ST_RXBIT,
        ST_RXACK,
        ST_STOP
    } twi_state_e;

    typedef struct packed {
        logic       scl;
        logic       low;
        logic [1:0] step;
    } eng_s;

endpackage

// File: rtl/twi_line_engine.sv
module twi_line_engine
    import twi_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     tick_i,
    input  logic     active_i,
    input  twi_sym_e sym_i,
    input  logic     bit_i,
    output logic     scl_o,
    output logic     sda_low_o,
    output logic     adv_o
);

    eng_s eng_d, eng_q;
    logic last_step;

    always_comb begin
        eng_d = eng_q;
        case (sym_i)
            SYM_START:  last_step = (eng_q.step == 2'd1);
            SYM_BIT:    last_step = (eng_q.step == 2'd2);
            SYM_RSTART: last_step = (eng_q.step == 2'd3);
            SYM_STOP:   last_step = (eng_q.step == 2'd2);
            default:    last_step = 1'b1;
        endcase

        if (tick_i && active_i) begin
            case (sym_i)
                SYM_START: begin
                    if (eng_q.step == 2'd0) eng_d.low = 1'b1;
                    else                    eng_d.scl = 1'b0;
                end
                SYM_BIT: begin
                    case (eng_q.step)
                        2'd0:    eng_d.low = ~bit_i;
                        2'd1:    eng_d.scl = 1'b1;
                        default: eng_d.scl = 1'b0;
                    endcase
                end
                SYM_RSTART: begin
                    case (eng_q.step)
                        2'd0:    eng_d.low = 1'b0;
                        2'd1:    eng_d.scl = 1'b1;
                        2'd2:    eng_d.low = 1'b1;
                        default: eng_d.scl = 1'b0;
                    endcase
                end
                default: begin
                    case (eng_q.step)
                        2'd0:    eng_d.low = 1'b1;
                        2'd1:    eng_d.scl = 1'b1;
                        default: eng_d.low = 1'b0;
                    endcase
                end
            endcase
            eng_d.step = last_step ? 2'd0 : eng_q.step + 2'd1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            eng_q <= '{scl: 1'b1, low: 1'b0, step: 2'd0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign scl_o     = eng_q.scl;
    assign sda_low_o = eng_q.low;
    assign adv_o     = tick_i & active_i & last_step;

endmodule

// File: rtl/twi_xfer_ctl.sv
module twi_xfer_ctl
    import twi_pkg::*;
#(
    parameter int TX_BYTES = 8,
    parameter int RX_BYTES = 8,
    parameter int CW       = 4,
    parameter int TXW      = 3,
    parameter int RXW      = 3
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           start_i,
    input  logic [1:0]     cmd_i,
    input  logic [CW-1:0]  count_i,
    input  logic           adv_i,
    input  logic           sda_i,
    input  logic [7:0]     fetch_byte_i,
    output logic [TXW-1:0] fetch_idx_o,
    output logic           active_o,
    output twi_sym_e       sym_o,
    output logic           bit_o,
    output logic           busy_o,
    output logic           done_o,
    output logic           err_o,
    output logic           rx_we_o,
    output logic [RXW-1:0] rx_idx_o,
    output logic [7:0]     rx_byte_o
);

    localparam logic [CW-1:0] WR_MAX = CW'(TX_BYTES);
    localparam logic [CW-1:0] RD_MAX = CW'(RX_BYTES + 3);
    localparam logic [CW-1:0] ONE    = CW'(1);
    localparam logic [CW-1:0] THREE  = CW'(3);
    localparam logic [CW-1:0] FOUR   = CW'(4);

    typedef struct packed {
        twi_state_e    st;
        logic          rd;
        logic [CW-1:0] count;
        logic [CW-1:0] byte_idx;
        logic [CW-1:0] rx_idx;
        logic [2:0]    bits;
        logic [7:0]    sh;
        logic          busy;
        logic          done;
        logic          err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic wr_ok, rd_ok, rx_last, tx_last;

    assign wr_ok   = (cmd_i == CMD_WRITE) && (count_i >= ONE)  && (count_i <= WR_MAX);
    assign rd_ok   = (cmd_i == CMD_READ)  && (count_i >= FOUR) && (count_i <= RD_MAX);
    assign rx_last = (ctl_q.rx_idx + ONE) == (ctl_q.count - THREE);
    assign tx_last = (ctl_q.byte_idx + ONE) == ctl_q.count;

    // Byte to fetch from the transmit buffer on the next symbol boundary
    always_comb begin
        if (ctl_q.st == ST_START || ctl_q.st == ST_RSTART) fetch_idx_o = '0;
        else fetch_idx_o = TXW'(ctl_q.byte_idx + ONE);
    end

    // Symbol presented to the line engine
    always_comb begin
        active_o = 1'b1;
        bit_o    = 1'b1;
        sym_o    = SYM_BIT;
        case (ctl_q.st)
            ST_IDLE:   active_o = 1'b0;
            ST_START:  sym_o = SYM_START;
            ST_TXBIT:  bit_o = ctl_q.sh[7];
            ST_TXACK:  bit_o = 1'b1;
            ST_RSTART: sym_o = SYM_RSTART;
            ST_RXBIT:  bit_o = 1'b1;
            ST_RXACK:  bit_o = rx_last;
            default:   sym_o = SYM_STOP;
        endcase
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        rx_we_o    = 1'b0;
        rx_byte_o  = {ctl_q.sh[6:0], sda_i};
        rx_idx_o   = RXW'(ctl_q.rx_idx);

        if (ctl_q.st == ST_IDLE) begin
            if (start_i && (wr_ok || rd_ok)) begin
                ctl_d.st    = ST_START;
                ctl_d.rd    = rd_ok;
                ctl_d.count = count_i;
                ctl_d.err   = 1'b0;
                ctl_d.busy  = 1'b1;
            end
        end else if (adv_i) begin
            case (ctl_q.st)
                ST_START: begin
                    ctl_d.sh       = {fetch_byte_i[7:1], 1'b0};
                    ctl_d.byte_idx = '0;
                    ctl_d.bits     = 3'd0;
                    ctl_d.st       = ST_TXBIT;
                end
                ST_TXBIT: begin
                    ctl_d.sh   = {ctl_q.sh[6:0], 1'b0};
                    ctl_d.bits = ctl_q.bits + 3'd1;
                    if (ctl_q.bits == 3'd7) ctl_d.st = ST_TXACK;
                end
                ST_TXACK: begin
                    if (sda_i) begin
                        ctl_d.err = 1'b1;
                        ctl_d.st  = ST_STOP;
                    end else if (!ctl_q.rd) begin
                        if (tx_last) begin
                            ctl_d.st = ST_STOP;
                        end else begin
                            ctl_d.sh       = fetch_byte_i;
                            ctl_d.byte_idx = ctl_q.byte_idx + ONE;
                            ctl_d.bits     = 3'd0;
                            ctl_d.st       = ST_TXBIT;
                        end
                    end else begin
                        case (ctl_q.byte_idx)
                            CW'(0): begin
                                ctl_d.sh       = fetch_byte_i;
                                ctl_d.byte_idx = ONE;
                                ctl_d.bits     = 3'd0;
                                ctl_d.st       = ST_TXBIT;
                            end
                            CW'(1): ctl_d.st = ST_RSTART;
                            default: begin
                                ctl_d.rx_idx = '0;
                                ctl_d.bits   = 3'd0;
                                ctl_d.st     = ST_RXBIT;
                            end
                        endcase
                    end
                end
                ST_RSTART: begin
                    ctl_d.sh       = {fetch_byte_i[7:1], 1'b1};
                    ctl_d.byte_idx = CW'(2);
                    ctl_d.bits     = 3'd0;
                    ctl_d.st       = ST_TXBIT;
                end
                ST_RXBIT: begin
                    ctl_d.sh   = {ctl_q.sh[6:0], sda_i};
                    ctl_d.bits = ctl_q.bits + 3'd1;
                    if (ctl_q.bits == 3'd7) begin
                        rx_we_o  = 1'b1;
                        ctl_d.st = ST_RXACK;
                    end
                end
                ST_RXACK: begin
                    if (rx_last) begin
                        ctl_d.st = ST_STOP;
                    end else begin
                        ctl_d.rx_idx = ctl_q.rx_idx + ONE;
                        ctl_d.bits   = 3'd0;
                        ctl_d.st     = ST_RXBIT;
                    end
                end
                default: begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.busy = 1'b0;
                    ctl_d.done = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o = ctl_q.busy;
    assign done_o = ctl_q.done;
    assign err_o  = ctl_q.err;

endmodule

// File: rtl/twi_reg_master.sv
module twi_reg_master
    import twi_pkg::*;
#(
    parameter int TX_BYTES = 8,
    parameter int RX_BYTES = 8,
    localparam int MAXC = (TX_BYTES > RX_BYTES + 3) ? TX_BYTES : RX_BYTES + 3,
    localparam int CW   = $clog2(MAXC + 1),
    localparam int TXW  = (TX_BYTES > 1) ? $clog2(TX_BYTES) : 1,
    localparam int RXW  = (RX_BYTES > 1) ? $clog2(RX_BYTES) : 1
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  tick_i,
    input  logic                  start_i,
    input  logic [1:0]            cmd_i,
    input  logic [CW-1:0]         count_i,
    input  logic                  load_i,
    input  logic [TXW-1:0]        load_idx_i,
    input  logic [7:0]            load_byte_i,
    input  logic                  sda_i,
    output logic                  scl_o,
    output logic                  sda_low_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  err_o,
    output logic [RX_BYTES*8-1:0] rx_data_o
);

    typedef struct packed {
        logic [TX_BYTES-1:0][7:0] txb;
        logic [RX_BYTES-1:0][7:0] rxb;
    } bufs_t;

    bufs_t bufs_d, bufs_q;

    logic           adv;
    logic           active;
    twi_sym_e       sym;
    logic           sym_bit;
    logic [TXW-1:0] fetch_idx;
    logic [7:0]     fetch_byte;
    logic           rx_we;
    logic [RXW-1:0] rx_idx;
    logic [7:0]     rx_byte;

    twi_line_engine u_engine (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .active_i  (active),
        .sym_i     (sym),
        .bit_i     (sym_bit),
        .scl_o     (scl_o),
        .sda_low_o (sda_low_o),
        .adv_o     (adv)
    );

    twi_xfer_ctl #(
        .TX_BYTES (TX_BYTES),
        .RX_BYTES (RX_BYTES),
        .CW       (CW),
        .TXW      (TXW),
        .RXW      (RXW)
    ) u_ctl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (start_i),
        .cmd_i        (cmd_i),
        .count_i      (count_i),
        .adv_i        (adv),
        .sda_i        (sda_i),
        .fetch_byte_i (fetch_byte),
        .fetch_idx_o  (fetch_idx),
        .active_o     (active),
        .sym_o        (sym),
        .bit_o        (sym_bit),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .err_o        (err_o),
        .rx_we_o      (rx_we),
        .rx_idx_o     (rx_idx),
        .rx_byte_o    (rx_byte)
    );

    assign fetch_byte = (int'(fetch_idx) < TX_BYTES) ? bufs_q.txb[fetch_idx] : 8'h00;

    always_comb begin
        bufs_d = bufs_q;
        if (load_i && !busy_o && (int'(load_idx_i) < TX_BYTES)) begin
            bufs_d.txb[load_idx_i] = load_byte_i;
        end
        if (rx_we && (int'(rx_idx) < RX_BYTES)) begin
            bufs_d.rxb[rx_idx] = rx_byte;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bufs_q <= '0;
        end else begin
            bufs_q <= bufs_d;
        end
    end

    for (genvar g = 0; g < RX_BYTES; g++) begin : g_rx
        assign rx_data_o[g*8 +: 8] = bufs_q.rxb[g];
    end

endmodule

// File: rtl/twi_reg_master_chk.sv
module twi_reg_master_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic tick_i,
    input logic scl_o,
    input logic sda_low_o,
    input logic busy_o,
    input logic done_o,
    input logic err_o
);

    p_idle_lines_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (scl_o && !sda_low_o));

    p_one_change_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (scl_o != $past(scl_o) || sda_low_o != $past(sda_low_o))
        |-> ($past(tick_i) && (scl_o == $past(scl_o) || sda_low_o == $past(sda_low_o))));

    p_done_closes_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && $past(busy_o)));

    p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_err_in_xfer_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(err_o) |-> busy_o);

endmodule

bind twi_reg_master twi_reg_master_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .scl_o     (scl_o),
    .sda_low_o (sda_low_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_o     (err_o)
);

// File: tb/tb_twi_reg_master.sv
module tb_twi_reg_master;

    localparam int TXB = 8;
    localparam int RXB = 8;
    localparam int CW  = 4;
    localparam int TXW = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    cmd = 2'd0;
    logic [CW-1:0] count = '0;
    logic          load = 1'b0;
    logic [TXW-1:0] load_idx = '0;
    logic [7:0]    load_byte = 8'h00;
    logic          slave_low = 1'b0;
    logic          sda_in;
    logic          scl, sda_low, busy, done, err;
    logic [RXB*8-1:0] rxd;

    assign sda_in = ~(sda_low | slave_low);

    twi_reg_master #(.TX_BYTES(TXB), .RX_BYTES(RXB)) dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tick_i      (tick),
        .start_i     (start),
        .cmd_i       (cmd),
        .count_i     (count),
        .load_i      (load),
        .load_idx_i  (load_idx),
        .load_byte_i (load_byte),
        .sda_i       (sda_in),
        .scl_o       (scl),
        .sda_low_o   (sda_low),
        .busy_o      (busy),
        .done_o      (done),
        .err_o       (err),
        .rx_data_o   (rxd)
    );

    int checks = 0;
    int errors = 0;
    int cyc_cnt = 0;
    logic exp_scl = 1'b1, exp_low = 1'b0, exp_busy = 1'b0, exp_done = 1'b0, exp_err = 1'b0;
    logic cmp_en = 1'b0;
    string cur_req = "R1";
    logic [7:0] mem [TXB];
    logic [7:0] rxexp [RXB];
    int q[$];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Reference comparison on every clock, away from the active edge
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(scl == exp_scl, cur_req, "scl", scl, exp_scl);
            chk(sda_low == exp_low, cur_req, "sda_low", sda_low, exp_low);
            chk(busy == exp_busy, "R10", "busy", busy, exp_busy);
            chk(done == exp_done, "R10", "done", done, exp_done);
            chk(err == exp_err, "R11", "err", err, exp_err);
        end
    end

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt == 150000) begin
            errors++;
            checks++;
            $display("FAIL R10 watchdog: actual=%0d expected=<150000", cyc_cnt);
            finish_run();
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    // Entry: bit0 scl, bit1 master pull-down, bit2 slave pull-down, bit3 error expected
    task automatic put(input bit s, input bit l, input bit sl, input bit e);
        q.push_back(int'({e, sl, l, s}));
    endtask

    task automatic seq_start();
        put(1, 1, 0, 0); put(0, 1, 0, 0);
    endtask

    task automatic seq_rstart();
        put(0, 0, 0, 0); put(1, 0, 0, 0); put(1, 1, 0, 0); put(0, 1, 0, 0);
    endtask

    task automatic seq_stop();
        put(0, 1, 0, 0); put(1, 1, 0, 0); put(1, 0, 0, 0);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit ack, output bit nack);
        for (int k = 7; k >= 0; k--) begin
            put(0, !b[k], 0, 0); put(1, !b[k], 0, 0); put(0, !b[k], 0, 0);
        end
        put(0, 0, ack, 0); put(1, 0, ack, 0); put(0, 0, 0, !ack);
        nack = !ack;
    endtask

    task automatic recv_byte(input logic [7:0] d, input bit last);
        for (int k = 7; k >= 0; k--) begin
            put(0, 0, !d[k], 0); put(1, 0, !d[k], 0); put(0, 0, 0, 0);
        end
        put(0, !last, 0, 0); put(1, !last, 0, 0); put(0, !last, 0, 0);
    endtask

    task automatic play(input bit late_start, input bit busy_load);
        int e;
        bit first;
        first = 1'b1;
        while (q.size() > 0) begin
            e = q.pop_front();
            cyc();
            tick = 1'b1;
            if (late_start && q.size() == 0) begin
                start = 1'b1; cmd = 2'd2; count = CW'(3);
            end
            if (busy_load && first) begin
                load = 1'b1; load_idx = TXW'(TXB - 1); load_byte = 8'h00;
            end
            first = 1'b0;
            cyc();
            tick = 1'b0; start = 1'b0; load = 1'b0;
            exp_scl = e[0];
            exp_low = e[1];
            slave_low = e[2];
            if (e[3]) exp_err = 1'b1;
            if (q.size() == 0) begin
                exp_busy = 1'b0;
                exp_done = 1'b1;
            end
            cyc();
            exp_done = 1'b0;
        end
    endtask

    task automatic launch(input logic [1:0] c, input int n, input bit ok);
        cyc();
        start = 1'b1; cmd = c; count = CW'(n);
        cyc();
        start = 1'b0;
        if (ok) begin
            exp_busy = 1'b1;
            exp_err = 1'b0;
        end
    endtask

    task automatic idle_ticks(input int n);
        repeat (n) begin
            cyc(); tick = 1'b1;
            cyc(); tick = 1'b0;
        end
    endtask

    task automatic load_buf(input int idx, input logic [7:0] b);
        cyc();
        load = 1'b1; load_idx = TXW'(idx); load_byte = b;
        cyc();
        load = 1'b0;
        mem[idx] = b;
    endtask

    task automatic do_write(input int n, input int ackmask, input bit late, input bit bload);
        bit nack;
        launch(2'd2, n, 1'b1);
        seq_start();
        nack = 1'b0;
        for (int i = 0; i < n && !nack; i++) begin
            send_byte((i == 0) ? (mem[0] & 8'hFE) : mem[i], ackmask[i], nack);
        end
        seq_stop();
        play(late, bload);
    endtask

    task automatic do_read(input int n, input int ackmask, input int seed);
        bit nack;
        logic [7:0] d;
        launch(2'd1, n, 1'b1);
        seq_start();
        send_byte(mem[0] & 8'hFE, ackmask[0], nack);
        if (!nack) send_byte(mem[1], ackmask[1], nack);
        if (!nack) begin
            seq_rstart();
            send_byte(mem[0] | 8'h01, ackmask[2], nack);
        end
        if (!nack) begin
            for (int j = 0; j < n - 3; j++) begin
                d = 8'((j * 37 + seed) & 255);
                recv_byte(d, j == n - 4);
                rxexp[j] = d;
            end
        end
        seq_stop();
        play(1'b0, 1'b0);
    endtask

    task automatic check_rx();
        for (int j = 0; j < RXB; j++) begin
            chk(rxd[j*8 +: 8] == rxexp[j], "R8", "rx byte", int'(rxd[j*8 +: 8]), int'(rxexp[j]));
        end
    endtask

    initial begin
        for (int j = 0; j < RXB; j++) rxexp[j] = 8'h00;
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        chk(scl == 1'b1 && sda_low == 1'b0, "R1", "reset lines", {scl, sda_low}, 2'b10);
        chk(!busy && !done && !err, "R1", "reset flags", {busy, done, err}, 0);
        cyc();
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // R2: ticks while idle do nothing
        cur_req = "R2";
        idle_ticks(4);
        chk(scl == 1'b1 && sda_low == 1'b0, "R2", "idle tick lines", {scl, sda_low}, 2'b10);

        load_buf(0, 8'hC1); load_buf(1, 8'h13); load_buf(2, 8'h21); load_buf(3, 8'h5A);
        load_buf(4, 8'hF0); load_buf(5, 8'h0F); load_buf(6, 8'h96); load_buf(7, 8'h3C);

        // R3: rejected requests
        cur_req = "R3";
        launch(2'd0, 3, 1'b0);  chk(!busy, "R3", "cmd 0", busy, 0);
        launch(2'd3, 3, 1'b0);  chk(!busy, "R3", "cmd 3", busy, 0);
        launch(2'd2, 0, 1'b0);  chk(!busy, "R3", "write count 0", busy, 0);
        launch(2'd2, 9, 1'b0);  chk(!busy, "R3", "write count 9", busy, 0);
        launch(2'd1, 3, 1'b0);  chk(!busy, "R3", "read count 3", busy, 0);
        launch(2'd1, 12, 1'b0); chk(!busy, "R3", "read count 12", busy, 0);
        idle_ticks(2);

        // R5 and R4: three-byte write, plus R10 start on the final stop tick
        cur_req = "R5";
        do_write(3, 'h7, 1'b1, 1'b0);
        idle_ticks(3);
        chk(!busy, "R10", "late start ignored", busy, 0);

        // R12: load during a full-length write is ignored
        cur_req = "R12";
        do_write(8, 'hFF, 1'b0, 1'b1);

        // R6: missing acknowledge on byte 1 of a five-byte write
        cur_req = "R6";
        do_write(5, 'h1D, 1'b0, 1'b0);
        idle_ticks(2);
        chk(err == 1'b1, "R11", "err sticky", err, 1);

        // R7 / R9: two-byte read, err cleared by accepted start (R11)
        cur_req = "R7";
        do_read(5, 'h7, 5);
        chk(err == 1'b0, "R11", "err cleared", err, 0);
        check_rx();

        // R6 in read: third address byte not acknowledged
        cur_req = "R6";
        do_read(4, 'h3, 200);
        chk(err == 1'b1, "R6", "read nack err", err, 1);
        check_rx();

        // R8 / R9: full-depth read
        cur_req = "R9";
        do_read(11, 'h7, 91);
        check_rx();

        idle_ticks(3);
        finish_run();
    end

endmodule